// File: doc/BRIEF.md
# Periodic Interval Timer

This block produces the regular tick that an operating-system scheduler uses as its time base. A free-running 4-bit prescaler divides the system clock by sixteen. Each prescaled tick advances a 20-bit interval counter. When that counter reaches the programmed interval value it returns to zero, a 12-bit wrap counter goes up by one, and a sticky status flag is set. The flag drives the interrupt output when the interrupt is enabled.

Software reaches the block through a strobe-based register port with four word addresses. One address reads the counter pair and clears the flag and the wrap counter. A second address returns the same pair and clears nothing. An interrupt handler that runs late can therefore read the wrap count to learn how many ticks it missed. Clearing the enable bit does not stop the timer at once. The counter first runs on to its wrap point, so the last period is always complete.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset the mode register reads 0x000FFFFF: the interval is all ones, enable is 0 and interrupt enable is 0. The status, value and image addresses all read 0, and `tick_irq` is low.
- R2: The register addresses are 0 (mode), 1 (status), 2 (value, clears on read) and 3 (image). In the mode register, bits [19:0] hold the interval, bit 24 is enable and bit 25 is interrupt enable. A mode write is visible on the next read. A read returns its data in the same cycle the read strobe is presented.
- R3: While the timer runs, the interval counter advances once every 16 clock cycles. A mode write that sets enable while enable is 0 restarts the prescaler from zero, so the first advance comes 16 edges after that write.
- R4: On a prescaled tick where the interval counter is at or above the interval value, the counter goes to 0, the wrap counter goes up by one, and status bit 0 is set.
- R5: The value read returns the interval counter in bits [19:0] and the wrap counter in bits [31:20]. At that clock edge it clears the status flag and the wrap counter. If a wrap falls in the same cycle, the flag reads 1 and the wrap counter reads 1 afterwards.
- R6: The image read returns the same fields as the value read and leaves the flag and the wrap counter unchanged.
- R7: `tick_irq` is high exactly when the status flag is set and interrupt enable is 1.
- R8: After enable is cleared, the counter keeps running until it wraps to 0. It then stays at 0 with the prescaler held, and no further wraps occur.
- R9: The wrap counter rolls over from 4095 to 0 and does not saturate.
- R10: Writes to addresses 1, 2 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read, 0 otherwise |
| tick_irq | output | 1 | Interrupt request |

## Verification
Read data is combinational from registered state, so it is due in the same cycle as the strobe. A read's clearing effect, a mode write, and counter or flag changes all appear after the next rising edge. The first counter step after enabling comes 16 edges after the enabling write. The bench drives inputs on the falling edge and samples 1 ns later. At that point it compares against a reference updated on every rising edge from the same inputs, so each expected value lines up with the edge that produced it. Two directed reads around 65,536 cycles of interval 0 pin the wrap-counter rollover to its exact cycle window.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  localparam int DATA_W     = 32;
  localparam int DEF_CNT_W  = 20;
  localparam int DEF_TICK_W = 12;
  localparam int DEF_PRE_W  = 4;
  localparam int EN_BIT     = 24;
  localparam int IE_BIT     = 25;

  typedef enum logic [1:0] {
    ADDR_MODE  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_VALUE = 2'd2,
    ADDR_IMAGE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/ptt_prescaler.sv
module ptt_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  output logic             tick,
  output logic [PRE_W-1:0] pre_cnt
);
  localparam logic [PRE_W-1:0] LAST = '1;

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             adv;

  assign adv = run && !restart;

  always_comb begin
    cnt_d = '0;
    if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick    = adv && (cnt_q == LAST);
  assign pre_cnt = cnt_q;
endmodule

// File: rtl/ptt_interval_core.sv
module ptt_interval_core #(
  parameter int CNT_W  = 20,
  parameter int TICK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  interval,
  input  logic              rd_clear,
  output logic [CNT_W-1:0]  pic,
  output logic [TICK_W-1:0] sec,
  output logic              flag
);
  logic [CNT_W-1:0]  pic_q, pic_d;
  logic [TICK_W-1:0] sec_q, sec_d, sec_base;
  logic              flag_q, flag_d;
  logic              wrap, upd;

  assign wrap = tick && (pic_q >= interval);
  assign upd  = tick || rd_clear;

  always_comb begin
    pic_d = pic_q;
    if (tick) pic_d = wrap ? '0 : pic_q + 1'b1;
    sec_base = rd_clear ? '0 : sec_q;
    sec_d    = sec_base + {{(TICK_W-1){1'b0}}, wrap};
    flag_d   = wrap || (flag_q && !rd_clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pic_q  <= '0;
      sec_q  <= '0;
      flag_q <= 1'b0;
    end else if (upd) begin
      pic_q  <= pic_d;
      sec_q  <= sec_d;
      flag_q <= flag_d;
    end
  end

  assign pic  = pic_q;
  assign sec  = sec_q;
  assign flag = flag_q;
endmodule

// File: rtl/ptt_regs.sv
module ptt_regs
  import ptt_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int TICK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              write,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  pic,
  input  logic [TICK_W-1:0] sec,
  input  logic              flag,
  output logic [CNT_W-1:0]  interval,
  output logic              en,
  output logic              ie,
  output logic              restart,
  output logic              rd_clear,
  output logic [DATA_W-1:0] rdata
);
  logic [CNT_W-1:0] iv_q, iv_d;
  logic             en_q, en_d, ie_q, ie_d;
  logic             mode_wr, rd;
  logic             unused_wdata;

  assign mode_wr      = valid && write && (addr == ADDR_MODE);
  assign rd           = valid && !write;
  assign restart      = mode_wr && wdata[EN_BIT] && !en_q;
  assign rd_clear     = rd && (addr == ADDR_VALUE);
  assign unused_wdata = ^{wdata[DATA_W-1:IE_BIT+1], wdata[EN_BIT-1:CNT_W]};

  always_comb begin
    iv_d = wdata[CNT_W-1:0];
    en_d = wdata[EN_BIT];
    ie_d = wdata[IE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iv_q <= '1;
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (mode_wr) begin
      iv_q <= iv_d;
      en_q <= en_d;
      ie_q <= ie_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        ADDR_MODE: begin
          rdata[CNT_W-1:0] = iv_q;
          rdata[EN_BIT]    = en_q;
          rdata[IE_BIT]    = ie_q;
        end
        ADDR_STAT: rdata[0] = flag;
        default: begin
          rdata[CNT_W-1:0]      = pic;
          rdata[CNT_W +: TICK_W] = sec;
        end
      endcase
    end
  end

  assign interval = iv_q;
  assign en       = en_q;
  assign ie       = ie_q;
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
  import ptt_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int TICK_W = DEF_TICK_W,
  parameter int PRE_W  = DEF_PRE_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tick_irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_sync;
  logic              tick_w, run_w, restart_w, rd_clear_w;
  logic              en_w, ie_w, flag_w;
  logic [PRE_W-1:0]  pre_w;
  logic [CNT_W-1:0]  pic_w, interval_w;
  logic [TICK_W-1:0] sec_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  assign run_w = en_w || (pic_w != '0);

  ptt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n_sync), .run(run_w), .restart(restart_w),
    .tick(tick_w), .pre_cnt(pre_w)
  );

  ptt_interval_core #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_core (
    .clk(clk), .rst_n(rst_n_sync), .tick(tick_w), .interval(interval_w),
    .rd_clear(rd_clear_w), .pic(pic_w), .sec(sec_w), .flag(flag_w)
  );

  ptt_regs #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .valid(bus_valid), .write(bus_write),
    .addr(bus_addr), .wdata(bus_wdata), .pic(pic_w), .sec(sec_w),
    .flag(flag_w), .interval(interval_w), .en(en_w), .ie(ie_w),
    .restart(restart_w), .rd_clear(rd_clear_w), .rdata(bus_rdata)
  );

  assign tick_irq = flag_w && ie_w;
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
  parameter int CNT_W  = 20,
  parameter int TICK_W = 12,
  parameter int PRE_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [1:0]        bus_addr,
  input logic              tick,
  input logic              rd_clear,
  input logic              en,
  input logic              ie,
  input logic              flag,
  input logic              irq,
  input logic [PRE_W-1:0]  pre,
  input logic [CNT_W-1:0]  pic,
  input logic [CNT_W-1:0]  interval,
  input logic [TICK_W-1:0] sec
);
  localparam logic [PRE_W-1:0]  PRE_LAST = '1;
  localparam logic [TICK_W-1:0] SEC_MAX  = '1;

  p_step_after_prescale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pic) |-> ($past(pre) == PRE_LAST));

  p_wrap_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (pic >= interval)) |=> ((pic == '0) && flag));

  p_value_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clear && !tick) |=> ((sec == '0) && !flag));

  p_image_read_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && (bus_addr == 2'd3) && !tick) |=> ($stable(sec) && $stable(flag)));

  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  p_stopped_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && (pic == '0)) |=> ((pic == '0) && (pre == '0)));

  p_sec_rolls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (pic >= interval) && !rd_clear && (sec == SEC_MAX)) |=> (sec == '0));
endmodule

bind periodic_tick_timer ptt_checker #(.CNT_W(CNT_W), .TICK_W(TICK_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .tick(tick_w), .rd_clear(rd_clear_w), .en(en_w), .ie(ie_w),
  .flag(flag_w), .irq(tick_irq), .pre(pre_w), .pic(pic_w), .interval(interval_w),
  .sec(sec_w)
);

// File: tb/periodic_tick_timer_tb_top.sv
`timescale 1ns/1ps
module periodic_tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_valid = 1'b0, b_write = 1'b0;
  logic [1:0]  b_addr = 2'd0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  periodic_tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(b_valid), .bus_write(b_write),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata), .tick_irq(irq)
  );

  // reference state, updated from the requirements on each rising edge
  logic [3:0]  m_pre;
  logic [19:0] m_pic, m_iv;
  logic [11:0] m_sec;
  logic        m_flag, m_en, m_ie;

  always @(posedge clk or negedge rst_n) begin
    logic run, restart, tick, wrap, clr, mwr;
    if (!rst_n) begin
      m_pre = 0; m_pic = 0; m_sec = 0; m_flag = 0;
      m_iv = 20'hFFFFF; m_en = 0; m_ie = 0;
    end else begin
      mwr     = b_valid && b_write && b_addr == 2'd0;
      run     = m_en || (m_pic != 0);
      restart = mwr && b_wdata[24] && !m_en;
      tick    = run && !restart && m_pre == 4'hF;
      wrap    = tick && (m_pic >= m_iv);
      clr     = b_valid && !b_write && b_addr == 2'd2;
      m_pre   = (run && !restart) ? m_pre + 4'd1 : 4'd0;
      if (tick) m_pic = wrap ? 20'd0 : m_pic + 20'd1;
      m_sec  = (clr ? 12'd0 : m_sec) + {11'd0, wrap};
      m_flag = wrap || (m_flag && !clr);
      if (mwr) begin
        m_iv = b_wdata[19:0]; m_en = b_wdata[24]; m_ie = b_wdata[25];
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    exp_rd = {6'd0, m_ie, m_en, 4'd0, m_iv};
      2'd1:    exp_rd = {31'd0, m_flag};
      default: exp_rd = {m_sec, m_pic};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic [1:0] a,
                     input logic [31:0] d, input string tag);
    @(negedge clk);
    b_valid = v; b_write = w; b_addr = a; b_wdata = d;
    #1;
    if (v && !w) chk(tag, rdata, exp_rd(a));
    chk("R7", {31'd0, irq}, {31'd0, m_flag && m_ie});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 32'd0, "R7");
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    cyc(1, 0, 2'd0, 0, "R1"); chk("R1", rdata, 32'h000FFFFF);
    cyc(1, 0, 2'd1, 0, "R1"); chk("R1", rdata, 32'h0);
    cyc(1, 0, 2'd2, 0, "R1"); chk("R1", rdata, 32'h0);
    cyc(1, 0, 2'd3, 0, "R1"); chk("R1", rdata, 32'h0);
    chk("R1", {31'd0, irq}, 32'd0);
    // R2 mode write and readback
    cyc(1, 1, 2'd0, 32'h0300_0002, "R2");
    cyc(1, 0, 2'd0, 0, "R2"); chk("R2", rdata, 32'h0300_0002);
    // R3 first step 16 edges after enabling write: read number 15 sees 0, 16 sees 1
    for (int i = 0; i < 14; i++) cyc(1, 0, 2'd3, 0, "R3");
    cyc(1, 0, 2'd3, 0, "R3"); chk("R3", rdata, 32'd0);
    cyc(1, 0, 2'd3, 0, "R3"); chk("R3", rdata, 32'd1);
    // R4 wrap after interval+1 steps
    for (int i = 0; i < 40; i++) cyc(1, 0, 2'd3, 0, "R4");
    cyc(1, 0, 2'd1, 0, "R4"); chk("R4", rdata, 32'd1);
    // R5 clear on value read
    cyc(1, 0, 2'd2, 0, "R5");
    cyc(1, 0, 2'd1, 0, "R5");
    cyc(1, 0, 2'd3, 0, "R5");
    // R6 image keeps state
    idle(60);
    cyc(1, 0, 2'd3, 0, "R6"); cyc(1, 0, 2'd3, 0, "R6");
    cyc(1, 0, 2'd1, 0, "R6");
    // R10 writes elsewhere ignored
    cyc(1, 1, 2'd1, 32'hFFFF_FFFF, "R10");
    cyc(1, 1, 2'd2, 32'hFFFF_FFFF, "R10");
    cyc(1, 1, 2'd3, 32'h1234_5678, "R10");
    cyc(1, 0, 2'd0, 0, "R10"); chk("R10", rdata, 32'h0300_0002);
    cyc(1, 0, 2'd1, 0, "R10");
    cyc(1, 0, 2'd3, 0, "R10");
    // R8 disable: run to wrap then stop
    cyc(1, 1, 2'd0, 32'h0200_0005, "R8");
    for (int i = 0; i < 200; i++) cyc(1, 0, 2'd3, 0, "R8");
    cyc(1, 0, 2'd2, 0, "R8"); chk("R8", {12'd0, rdata[19:0]}, 32'd0);
    idle(50);
    cyc(1, 0, 2'd2, 0, "R8"); chk("R8", rdata, 32'd0);
    // R9 rollover of the wrap counter with interval 0
    cyc(1, 1, 2'd0, 32'h0100_0000, "R9");
    cyc(1, 0, 2'd2, 0, "R9");
    idle(65528);
    cyc(1, 0, 2'd3, 0, "R9"); chk("R9", rdata, 32'hFFF0_0000);
    idle(9);
    cyc(1, 0, 2'd3, 0, "R9"); chk("R9", rdata, 32'h0000_0000);
    cyc(1, 0, 2'd1, 0, "R9"); chk("R9", rdata, 32'd1);
    // random mix
    for (int k = 0; k < 6000; k++) begin
      int unsigned r;
      logic [1:0] a;
      r = $urandom % 10;
      a = 2'($urandom % 4);
      if (r == 0)
        cyc(1, 1, 2'd0, {6'd0, 1'($urandom), 1'(($urandom % 4) != 0), 4'd0, 20'($urandom % 5)}, "R2");
      else if (r < 5)
        cyc(1, 0, a, 0, a == 2'd0 ? "R2" : a == 2'd1 ? "R4" : a == 2'd2 ? "R5" : "R6");
      else
        idle(1);
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule